// File: doc/BRIEF.md
# Microcontroller Buffer-Window Address Translator

This block sits between an 8-bit microcontroller's 64 KB external data space and a large byte-addressed buffer memory. It looks at each CPU access and steers it to one of three places. The first is the buffer memory, through one of several relocatable windows or block-addressed segments. The second is a small bank of translation registers kept inside the block. The third is an external register bank, reached through a select strobe. Buffer addresses are built from a block number times 2560 plus an offset within that block, or from a 1 KB-aligned base plus an offset. The result wraps modulo the configured memory size.

Two windows give the CPU a flat view of memory from a movable base. The first is large and covers the bottom 52 KB. The second is 4 KB. Above the windows lie three 2560-byte segments. Each segment follows its own block-number pointer, so firmware can walk sector data, subcode and headers independently. The five translation registers are 16 bits wide and are reached through byte accesses.

On reads, fetching the low byte freezes the high byte in a holding latch, so the two halves always belong to the same value. On writes, the low byte is staged, and the whole register changes only when the high byte arrives.

Top module: `bufwin_xlate`

## Requirements
- R1: CPU addresses 0x0000–0xCFFF map to buffer address (window_a_base × 1024 + cpu_addr). window_a_base is the 16-bit register at 0xFF00 (low byte) and 0xFF01 (high byte).
- R2: CPU addresses 0xD000–0xDFFF map to (window_b_base × 1024 + (cpu_addr − 0xD000)). window_b_base is the register at 0xFF02/0xFF03.
- R3: Three 2560-byte segments start at 0xE000, 0xEA00 and 0xF400. Segment n maps to (ptr_n × 2560 + (cpu_addr − segment base)). ptr_0, ptr_1 and ptr_2 are the registers at 0xFF04/05, 0xFF06/07 and 0xFF08/09.
- R4: For the buffer regions, buf_rd follows cpu_rd, buf_wr follows cpu_wr and cpu_rdata returns buf_rdata. buf_rd and buf_wr are never high together with reg_sel. Buffer write data is taken directly from cpu_wdata.
- R5: Addresses 0xFE00–0xFEFF read as 0x00. Writes there raise no strobe and change no register.
- R6: Addresses 0xFF10–0xFFFF raise reg_sel during a read or write, with reg_addr = cpu_addr[7:0], and cpu_rdata returns reg_rdata.
- R7: Addresses 0xFF00–0xFF0F belong to the internal bank and never raise reg_sel. 0xFF0A–0xFF0F are reserved: they read 0x00 and ignore writes.
- R8: Reading a register's low byte (even address) captures its high byte into a holding latch. A read of the odd address returns that latch, even if the register changed in between.
- R9: Writing an even address only stages the byte, and the register keeps its value. Writing the odd address then loads {high byte, staged byte} in one step.
- R10: Every buffer address is reduced modulo MEM_BYTES (default 2^24), so a window or segment that runs past the top continues at address 0.
- R11: After reset all translation registers and both latches are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU data-space address |
| cpu_rd | input | 1 | CPU read, one cycle per access |
| cpu_wr | input | 1 | CPU write, one cycle per access |
| cpu_wdata | input | 8 | CPU write data, also used as buffer and external register write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| buf_addr | output | 24 | Translated buffer memory address |
| buf_rd | output | 1 | Buffer read strobe |
| buf_wr | output | 1 | Buffer write strobe |
| buf_rdata | input | 8 | Buffer read data |
| reg_sel | output | 1 | External register bank select |
| reg_addr | output | 8 | External register offset |
| reg_rdata | input | 8 | External register read data |

## Verification
The bench probes the first and last byte of every region. A decoder with an off-by-one limit would send one edge byte to the wrong window or segment, or give it an offset that is one byte off. A segment pointer of 0xFFFF and a window base of 0xFFFF push the sum past 2^24. A design that truncated wrongly, or did not reduce the sum, would give the wrong address at that top edge. The bench also changes a register between reading its low half and its high half, and writes only the low half of a pointer. A design that reads the live high byte, or that commits on the low write, returns a torn value or moves a segment too early. Finally, the gap and the reserved local slots are written and read back. This catches a decoder that lets them leak a strobe or stale data.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;

  typedef enum logic [2:0] {
    RG_WIN_A  = 3'd0,
    RG_WIN_B  = 3'd1,
    RG_SEG    = 3'd2,
    RG_GAP    = 3'd3,
    RG_LOCAL  = 3'd4,
    RG_EXTREG = 3'd5
  } region_e;

  // index times unit size plus offset, in a width that cannot overflow
  function automatic logic [31:0] f_scaled(input logic [15:0] idx,
                                           input logic [15:0] unit,
                                           input logic [15:0] off);
    return 32'(idx) * 32'(unit) + 32'(off);
  endfunction

  function automatic logic [31:0] f_wrap(input logic [31:0] raw,
                                         input logic [31:0] mem_bytes);
    return raw % mem_bytes;
  endfunction

endpackage

// File: rtl/bufwin_decode.sv
module bufwin_decode
  import bufwin_pkg::*;
#(
  parameter int WIN_A_KB   = 52,
  parameter int WIN_B_KB   = 4,
  parameter int NSEG       = 3,
  parameter int SEG_BYTES  = 2560,
  parameter int LOCAL_SPAN = 16,
  localparam int SEG_IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int LOC_W     = $clog2(LOCAL_SPAN)
) (
  input  logic [15:0]          addr,
  output region_e              region,
  output logic [SEG_IDX_W-1:0] seg_idx,
  output logic [15:0]          offset,
  output logic [LOC_W-1:0]     loc_off
);

  localparam int WIN_B_BASE = WIN_A_KB * 1024;
  localparam int SEG_BASE   = WIN_B_BASE + WIN_B_KB * 1024;
  localparam int GAP_BASE   = SEG_BASE + NSEG * SEG_BYTES;
  localparam int REG_BASE   = 65536 - 256;

  logic [31:0] a;
  assign a       = 32'(addr);
  assign loc_off = addr[LOC_W-1:0];

  always_comb begin
    region  = RG_GAP;
    seg_idx = '0;
    offset  = '0;
    if (a < 32'(WIN_B_BASE)) begin
      region = RG_WIN_A;
      offset = addr;
    end else if (a < 32'(SEG_BASE)) begin
      region = RG_WIN_B;
      offset = 16'(a - 32'(WIN_B_BASE));
    end else if (a < 32'(GAP_BASE)) begin
      region = RG_SEG;
      for (int i = 0; i < NSEG; i++) begin
        if (a >= 32'(SEG_BASE + i * SEG_BYTES)) begin
          seg_idx = SEG_IDX_W'(i);
          offset  = 16'(a - 32'(SEG_BASE + i * SEG_BYTES));
        end
      end
    end else if (a < 32'(REG_BASE)) begin
      region = RG_GAP;
    end else if (32'(addr[7:0]) < 32'(LOCAL_SPAN)) begin
      region = RG_LOCAL;
    end else begin
      region = RG_EXTREG;
    end
  end

endmodule

// File: rtl/bufwin_regs.sv
module bufwin_regs #(
  parameter int NREG       = 5,
  parameter int LOCAL_SPAN = 16,
  localparam int LOC_W     = $clog2(LOCAL_SPAN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [LOC_W-1:0]     loc_off,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [NREG-1:0][15:0] val_q
);

  logic [7:0]       hold_q;
  logic [7:0]       stage_q;
  logic [LOC_W-2:0] idx;
  logic             is_hi;
  logic             idx_ok;

  assign idx    = loc_off[LOC_W-1:1];
  assign is_hi  = loc_off[0];
  assign idx_ok = 32'(idx) < 32'(NREG);

  // named events for the assertions
  logic lo_rd_evt, lo_wr_evt, hi_wr_evt;
  assign lo_rd_evt = rd_en && idx_ok && !is_hi;
  assign lo_wr_evt = wr_en && idx_ok && !is_hi;
  assign hi_wr_evt = wr_en && idx_ok &&  is_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      hold_q  <= '0;
      stage_q <= '0;
    end else begin
      if (lo_rd_evt) hold_q  <= val_q[idx][15:8];
      if (lo_wr_evt) stage_q <= wdata;
      if (hi_wr_evt) val_q[idx] <= {wdata, stage_q};
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (idx_ok) rdata = is_hi ? hold_q : val_q[idx][7:0];
  end

  AST_HOLD_ONLY_ON_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd_evt |=> $stable(hold_q)); // R8
  AST_REG_ONLY_ON_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr_evt |=> $stable(val_q)); // R9
  AST_STAGE_ONLY_ON_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_wr_evt |=> $stable(stage_q)); // R9

endmodule

// File: rtl/bufwin_addr_gen.sv
module bufwin_addr_gen
  import bufwin_pkg::*;
#(
  parameter int NSEG       = 3,
  parameter int SEG_BYTES  = 2560,
  parameter int GRAN_BYTES = 1024,
  parameter int ADDR_W     = 24,
  parameter int MEM_BYTES  = 2 ** 24,
  localparam int NREG      = 2 + NSEG,
  localparam int SEG_IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  region_e               region,
  input  logic [SEG_IDX_W-1:0]  seg_idx,
  input  logic [15:0]           offset,
  input  logic [NREG-1:0][15:0] bases,
  output logic [ADDR_W-1:0]     buf_addr
);

  logic [31:0] seg_raw [NSEG];
  logic [31:0] win_a_raw, win_b_raw, raw;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign seg_raw[g] = f_scaled(bases[2+g], 16'(SEG_BYTES), {4'b0, offset[11:0]});
  end

  assign win_a_raw = f_scaled(bases[0], 16'(GRAN_BYTES), offset);
  assign win_b_raw = f_scaled(bases[1], 16'(GRAN_BYTES), offset);

  always_comb begin
    case (region)
      RG_WIN_A: raw = win_a_raw;
      RG_WIN_B: raw = win_b_raw;
      RG_SEG:   raw = seg_raw[seg_idx];
      default:  raw = '0;
    endcase
  end

  assign buf_addr = ADDR_W'(f_wrap(raw, 32'(MEM_BYTES)));

endmodule

// File: rtl/bufwin_xlate.sv
module bufwin_xlate
  import bufwin_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int MEM_BYTES  = 2 ** 24,
  parameter int WIN_A_KB   = 52,
  parameter int WIN_B_KB   = 4,
  parameter int NSEG       = 3,
  parameter int SEG_BYTES  = 2560,
  parameter int LOCAL_SPAN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd,
  output logic              buf_wr,
  input  logic [7:0]        buf_rdata,
  output logic              reg_sel,
  output logic [7:0]        reg_addr,
  input  logic [7:0]        reg_rdata
);

  localparam int NREG      = 2 + NSEG;
  localparam int SEG_IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int LOC_W     = $clog2(LOCAL_SPAN);

  region_e               region;
  logic [SEG_IDX_W-1:0]  seg_idx;
  logic [15:0]           offset;
  logic [LOC_W-1:0]      loc_off;
  logic [NREG-1:0][15:0] bases;
  logic [7:0]            loc_rdata;
  logic                  in_buf, in_local, in_ext, in_gap;

  bufwin_decode #(
    .WIN_A_KB(WIN_A_KB), .WIN_B_KB(WIN_B_KB), .NSEG(NSEG),
    .SEG_BYTES(SEG_BYTES), .LOCAL_SPAN(LOCAL_SPAN)
  ) u_decode (
    .addr(cpu_addr), .region(region), .seg_idx(seg_idx),
    .offset(offset), .loc_off(loc_off)
  );

  assign in_buf   = (region == RG_WIN_A) || (region == RG_WIN_B) || (region == RG_SEG);
  assign in_local = (region == RG_LOCAL);
  assign in_ext   = (region == RG_EXTREG);
  assign in_gap   = (region == RG_GAP);

  bufwin_regs #(.NREG(NREG), .LOCAL_SPAN(LOCAL_SPAN)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rd_en(cpu_rd && in_local), .wr_en(cpu_wr && in_local),
    .loc_off(loc_off), .wdata(cpu_wdata),
    .rdata(loc_rdata), .val_q(bases)
  );

  bufwin_addr_gen #(
    .NSEG(NSEG), .SEG_BYTES(SEG_BYTES), .GRAN_BYTES(1024),
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)
  ) u_addr (
    .region(region), .seg_idx(seg_idx), .offset(offset),
    .bases(bases), .buf_addr(buf_addr)
  );

  assign buf_rd   = cpu_rd && in_buf;
  assign buf_wr   = cpu_wr && in_buf;
  assign reg_sel  = (cpu_rd || cpu_wr) && in_ext;
  assign reg_addr = cpu_addr[7:0];

  always_comb begin
    if (in_buf)        cpu_rdata = buf_rdata;
    else if (in_local) cpu_rdata = loc_rdata;
    else if (in_ext)   cpu_rdata = reg_rdata;
    else               cpu_rdata = 8'h00;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd || buf_wr) |-> !reg_sel); // R4
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> !(buf_rd || buf_wr || reg_sel)); // R5
  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gap && cpu_rd) |-> (cpu_rdata == 8'h00)); // R5
  AST_LOCAL_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    in_local |-> !reg_sel); // R7
  AST_ADDR_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd || buf_wr) |-> (32'(buf_addr) < 32'(MEM_BYTES))); // R10

endmodule

// File: tb/tb_bufwin_xlate.sv
module tb_bufwin_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [23:0] buf_addr;
  logic        buf_rd, buf_wr, reg_sel;
  logic [7:0]  buf_rdata, reg_addr;
  logic [7:0]  reg_rdata = 8'hC3;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign buf_rdata = buf_addr[7:0] ^ 8'hA5;

  bufwin_xlate dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_wr(buf_wr),
    .buf_rdata(buf_rdata), .reg_sel(reg_sel), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata)
  );

  // kind: 0 buffer, 1 gap, 2 external register
  localparam logic [41:0] VEC [0:13] = '{
    {16'h0000, 24'h000C00, 2'd0},  // R1 window A first byte
    {16'hCFFF, 24'h00DBFF, 2'd0},  // R1 window A last byte
    {16'hD000, 24'h040000, 2'd0},  // R2 window B first byte
    {16'hDFFF, 24'h040FFF, 2'd0},  // R2 window B last byte
    {16'hE000, 24'h001400, 2'd0},  // R3 segment 0 first
    {16'hE9FF, 24'h001DFF, 2'd0},  // R3 segment 0 last
    {16'hEA00, 24'h00A000, 2'd0},  // R3 segment 1 first
    {16'hF3FF, 24'h00A9FF, 2'd0},  // R3 segment 1 last
    {16'hF400, 24'hFFF600, 2'd0},  // R3 R10 segment 2 near top
    {16'hFDFF, 24'hFFFFFF, 2'd0},  // R3 R10 segment 2 last byte of memory
    {16'hFE00, 24'h000000, 2'd1},  // R5 gap first
    {16'hFEFF, 24'h000000, 2'd1},  // R5 gap last
    {16'hFF10, 24'h000000, 2'd2},  // R6 external first
    {16'hFFFF, 24'h000000, 2'd2}   // R6 external last
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk); #1 cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(posedge clk); #1 cpu_rd = 1'b0;
  endtask

  task automatic map_of(input logic [15:0] a, output logic [23:0] ba);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 ba = buf_addr;
    @(posedge clk); #1 cpu_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [23:0] ba;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    for (int i = 0; i < 10; i++) begin
      rd(16'hFF00 + 16'(i), d);
      chk(d == 8'h00, "R11 reset register", d, 0);
    end
    map_of(16'h0100, ba);
    chk(ba == 24'h000100, "R11 R1 window A at reset base", ba, 24'h000100);

    // program bases: A=3, B=0x100, seg0=2, seg1=0x10, seg2=0xFFFF
    wr(16'hFF00, 8'h03); wr(16'hFF01, 8'h00);
    wr(16'hFF02, 8'h00); wr(16'hFF03, 8'h01);
    wr(16'hFF04, 8'h02); wr(16'hFF05, 8'h00);
    wr(16'hFF06, 8'h10); wr(16'hFF07, 8'h00);
    wr(16'hFF08, 8'hFF); wr(16'hFF09, 8'hFF);

    for (int v = 0; v < 14; v++) begin
      logic [15:0] a;
      logic [23:0] ea;
      logic [1:0]  k;
      {a, ea, k} = VEC[v];
      @(negedge clk);
      cpu_addr = a; cpu_rd = 1'b1;
      #1;
      if (k == 2'd0) begin
        chk(buf_addr == ea, "R1/R2/R3 mapped address", buf_addr, ea);
        chk(buf_rd && !reg_sel && cpu_rdata == (ea[7:0] ^ 8'hA5),
            "R4 buffer read path", {buf_rd, reg_sel, cpu_rdata}, {2'b10, ea[7:0] ^ 8'hA5});
      end else if (k == 2'd1) begin
        chk(!buf_rd && !reg_sel && cpu_rdata == 8'h00, "R5 gap read",
            {buf_rd, reg_sel, cpu_rdata}, 0);
      end else begin
        chk(reg_sel && !buf_rd && reg_addr == a[7:0] && cpu_rdata == 8'hC3,
            "R6 external register read", {reg_sel, buf_rd, reg_addr, cpu_rdata},
            {2'b10, a[7:0], 8'hC3});
      end
      @(posedge clk); #1 cpu_rd = 1'b0;
    end

    // R4 buffer write strobe
    @(negedge clk);
    cpu_addr = 16'h0010; cpu_wdata = 8'h5E; cpu_wr = 1'b1;
    #1 chk(buf_wr && !buf_rd && !reg_sel && buf_addr == 24'h000C10,
           "R4 buffer write", {buf_wr, buf_rd, reg_sel, buf_addr}, {3'b100, 24'h000C10});
    @(posedge clk); #1 cpu_wr = 1'b0;

    // R6 external write
    @(negedge clk);
    cpu_addr = 16'hFF20; cpu_wr = 1'b1;
    #1 chk(reg_sel && !buf_wr && reg_addr == 8'h20, "R6 external write",
           {reg_sel, buf_wr, reg_addr}, {2'b10, 8'h20});
    @(posedge clk); #1 cpu_wr = 1'b0;

    // R7 local registers not forwarded, reserved slots
    @(negedge clk);
    cpu_addr = 16'hFF00; cpu_rd = 1'b1;
    #1 chk(!reg_sel && !buf_rd, "R7 local access forwarded", {reg_sel, buf_rd}, 0);
    @(posedge clk); #1 cpu_rd = 1'b0;
    wr(16'hFF0A, 8'h99); wr(16'hFF0B, 8'h99);
    rd(16'hFF0A, d); chk(d == 8'h00, "R7 reserved low", d, 0);
    rd(16'hFF0B, d); chk(d == 8'h00, "R7 reserved high", d, 0);

    // R5 gap write ignored
    @(negedge clk);
    cpu_addr = 16'hFE10; cpu_wdata = 8'h55; cpu_wr = 1'b1;
    #1 chk(!buf_wr && !reg_sel, "R5 gap write strobe", {buf_wr, reg_sel}, 0);
    @(posedge clk); #1 cpu_wr = 1'b0;
    map_of(16'h0000, ba);
    chk(ba == 24'h000C00, "R5 gap write left window A", ba, 24'h000C00);

    // R9 low write only stages
    wr(16'hFF06, 8'h77);
    map_of(16'hEA00, ba);
    chk(ba == 24'h00A000, "R9 staged low byte moved segment", ba, 24'h00A000);
    rd(16'hFF06, d); chk(d == 8'h10, "R9 low byte before commit", d, 8'h10);
    wr(16'hFF07, 8'h00);
    map_of(16'hEA00, ba);
    chk(ba == 24'h04A600, "R9 commit on high byte", ba, 24'h04A600);

    // R8 coherent read through holding latch
    rd(16'hFF04, d); chk(d == 8'h02, "R8 low byte", d, 8'h02);
    wr(16'hFF04, 8'h34); wr(16'hFF05, 8'h12);
    rd(16'hFF05, d); chk(d == 8'h00, "R8 latched high byte", d, 8'h00);
    rd(16'hFF04, d); chk(d == 8'h34, "R8 new low byte", d, 8'h34);
    rd(16'hFF05, d); chk(d == 8'h12, "R8 new high byte", d, 8'h12);
    map_of(16'hE000, ba);
    chk(ba == 24'hB60800, "R3 segment 0 after update", ba, 24'hB60800);

    // R10 window A wrap
    wr(16'hFF00, 8'hFF); wr(16'hFF01, 8'hFF);
    map_of(16'h03FF, ba);
    chk(ba == 24'hFFFFFF, "R10 window A top byte", ba, 24'hFFFFFF);
    map_of(16'h0400, ba);
    chk(ba == 24'h000000, "R10 window A wraps to zero", ba, 24'h000000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule